// File: doc/BRIEF.md
# Capture-Handshake PHY Register Bridge

This block is a memory-mapped slave that gives a host access to a PHY's indirect control-register space. The PHY side is reached through a narrow control port that carries a 16-bit staging word and four level requests: capture the word as an address, capture the word as data, read, and write. The PHY completes each request with a one-cycle acknowledge. The host builds each PHY access from separate steps. It loads the staging register, starts one command through a self-clearing command bit, and polls that bit until it returns to zero.

A PHY write takes three steps: capture the address, capture the data, then write. A PHY read captures the address and then issues read. The first read result after an address capture can be stale. For that reason, software issues read twice and keeps only the second value from the result register. The bridge runs one command at a time. A command bit that is never acknowledged stays set, so host polling software can detect the timeout.

Top module: `cr_bridge`

## Requirements
- R1: After reset, every command bit reads 0, all four requests are low, and the staging and result registers read 0.
- R2: A host write to offset 0x0C stores the low 16 bits of the write data. The stored value drives the PHY data lines and reads back zero-extended at 0x0C. The value changes on no other access.
- R3: A host write with bit 0 set, to the capture-address (0x14), capture-data (0x18), read (0x1C) or write (0x20) command offset, sets that bit while the bridge is idle. The matching request rises on the cycle after the write. Writing 0 starts nothing.
- R4: A command bit and its request remain 1 until the PHY acknowledges. Without an acknowledge they stay set indefinitely.
- R5: On the cycle after the acknowledge, the command bit reads 0 and the request is low. At most one request is ever high.
- R6: A command written while another command is busy is ignored. The busy command keeps its bit and request, and the ignored command bit reads 0.
- R7: The result register (offset 0x10) captures the PHY read data on the acknowledge of a read. It holds that value through acknowledges of other commands and through acknowledges that arrive while the bridge is idle.
- R8: Reads of unmapped offsets return 0. Bits 31:16 of the staging and result registers, and bits 31:1 of the command registers, read 0.
- R9: With a PHY that returns the previously read value on the first read after each address capture, a write followed by a double read returns the written data on the second read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe, one cycle per write |
| h_addr | input | 8 | Host byte offset for reads and writes |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr, combinational |
| cr_din | output | 16 | Staging word presented to the PHY |
| cr_cap_addr | output | 1 | Capture-address request |
| cr_cap_data | output | 1 | Capture-data request |
| cr_rd | output | 1 | Read request |
| cr_wr | output | 1 | Write request |
| cr_ack | input | 1 | PHY acknowledge, one cycle |
| cr_dout | input | 16 | PHY read data, valid with cr_ack |

## Verification
A wrong busy state is visible on the request lines on the first cycle after the faulty edge. It shows as a request that is missing, doubled or held past its acknowledge, and the command bit the host reads shows the same error in the same cycle. A wrong capture of the result register stays hidden until the host reads offset 0x10. The bench therefore reads it after every read, after acknowledges of other commands and after a spurious idle acknowledge. The stale-first-read PHY model makes any mix-up between first and second read values show up in the compared data.

// File: rtl/crb_pkg.sv
package crb_pkg;
   localparam int NCMD       = 4;
   localparam int IDX_CAPA   = 0;
   localparam int IDX_CAPD   = 1;
   localparam int IDX_RD     = 2;
   localparam int IDX_WR     = 3;
   typedef logic [NCMD-1:0] cmd_vec_t;
endpackage

// File: rtl/crb_host_if.sv
module crb_host_if #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int CR_W         = 16,
   parameter int OFS_DIN      = 'h0C,
   parameter int OFS_CMD_BASE = 'h14,
   parameter int CMD_STRIDE   = 4,
   parameter int NCMD         = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_wr,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [CR_W-1:0]   stage_q,
   output logic [NCMD-1:0]   cmd_start
);
   logic stage_hit;
   assign stage_hit = h_wr && (h_addr == ADDR_W'(OFS_DIN));

   always_ff @(posedge clk) begin
      if (!rst_n)         stage_q <= '0;
      else if (stage_hit) stage_q <= h_wdata[CR_W-1:0];
   end

   for (genvar k = 0; k < NCMD; k++) begin : g_dec
      assign cmd_start[k] = h_wr && h_wdata[0] &&
                            (h_addr == ADDR_W'(OFS_CMD_BASE + k*CMD_STRIDE));
   end
endmodule

// File: rtl/crb_cmd_ctl.sv
module crb_cmd_ctl #(
   parameter int NCMD   = 4,
   parameter int RD_IDX = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCMD-1:0] cmd_start,
   input  logic            cr_ack,
   output logic [NCMD-1:0] busy_q,
   output logic            rd_done
);
   logic idle;
   assign idle    = ~|busy_q;
   assign rd_done = cr_ack && busy_q[RD_IDX];

   for (genvar k = 0; k < NCMD; k++) begin : g_busy
      always_ff @(posedge clk) begin
         if (!rst_n)                     busy_q[k] <= 1'b0;
         else if (busy_q[k] && cr_ack)   busy_q[k] <= 1'b0;
         else if (idle && cmd_start[k])  busy_q[k] <= 1'b1;
      end
   end
endmodule

// File: rtl/crb_readback.sv
module crb_readback #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int CR_W         = 16,
   parameter int OFS_DIN      = 'h0C,
   parameter int OFS_DOUT     = 'h10,
   parameter int OFS_CMD_BASE = 'h14,
   parameter int CMD_STRIDE   = 4,
   parameter int NCMD         = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_done,
   input  logic [CR_W-1:0]   cr_dout,
   input  logic [CR_W-1:0]   stage_q,
   input  logic [NCMD-1:0]   busy_q,
   input  logic [ADDR_W-1:0] h_addr,
   output logic [DATA_W-1:0] h_rdata,
   output logic [CR_W-1:0]   dout_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)       dout_q <= '0;
      else if (rd_done) dout_q <= cr_dout;
   end

   always_comb begin
      h_rdata = '0;
      if (h_addr == ADDR_W'(OFS_DIN))  h_rdata = DATA_W'(stage_q);
      if (h_addr == ADDR_W'(OFS_DOUT)) h_rdata = DATA_W'(dout_q);
      for (int k = 0; k < NCMD; k++) begin
         if (h_addr == ADDR_W'(OFS_CMD_BASE + k*CMD_STRIDE))
            h_rdata = DATA_W'(busy_q[k]);
      end
   end
endmodule

// File: rtl/cr_bridge.sv
module cr_bridge #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 32,
   parameter int CR_W         = 16,
   parameter int OFS_DIN      = 'h0C,
   parameter int OFS_DOUT     = 'h10,
   parameter int OFS_CMD_BASE = 'h14,
   parameter int CMD_STRIDE   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_wr,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   output logic [DATA_W-1:0] h_rdata,
   output logic [CR_W-1:0]   cr_din,
   output logic              cr_cap_addr,
   output logic              cr_cap_data,
   output logic              cr_rd,
   output logic              cr_wr,
   input  logic              cr_ack,
   input  logic [CR_W-1:0]   cr_dout
);
   import crb_pkg::*;

   localparam int LAST_OFS = OFS_CMD_BASE + (NCMD-1)*CMD_STRIDE;

   if (CR_W > DATA_W) begin : g_bad_width
      $error("cr_bridge: CR_W must not exceed DATA_W");
   end
   if (LAST_OFS >= (1 << ADDR_W)) begin : g_bad_map
      $error("cr_bridge: command offsets exceed the address range");
   end

   logic [CR_W-1:0] stage_q;
   logic [CR_W-1:0] dout_q;
   cmd_vec_t        cmd_start;
   cmd_vec_t        busy_q;
   logic            rd_done;

   crb_host_if #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CR_W(CR_W), .OFS_DIN(OFS_DIN),
      .OFS_CMD_BASE(OFS_CMD_BASE), .CMD_STRIDE(CMD_STRIDE), .NCMD(NCMD)
   ) u_host (
      .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr),
      .h_wdata(h_wdata), .stage_q(stage_q), .cmd_start(cmd_start)
   );

   crb_cmd_ctl #(.NCMD(NCMD), .RD_IDX(IDX_RD)) u_ctl (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cr_ack(cr_ack),
      .busy_q(busy_q), .rd_done(rd_done)
   );

   crb_readback #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CR_W(CR_W), .OFS_DIN(OFS_DIN),
      .OFS_DOUT(OFS_DOUT), .OFS_CMD_BASE(OFS_CMD_BASE),
      .CMD_STRIDE(CMD_STRIDE), .NCMD(NCMD)
   ) u_rb (
      .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .cr_dout(cr_dout),
      .stage_q(stage_q), .busy_q(busy_q), .h_addr(h_addr),
      .h_rdata(h_rdata), .dout_q(dout_q)
   );

   assign cr_din      = stage_q;
   assign cr_cap_addr = busy_q[IDX_CAPA];
   assign cr_cap_data = busy_q[IDX_CAPD];
   assign cr_rd       = busy_q[IDX_RD];
   assign cr_wr       = busy_q[IDX_WR];
endmodule

// File: rtl/crb_checker.sv
module crb_checker #(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int CR_W    = 16,
   parameter int OFS_DIN = 'h0C
) (
   input logic              clk,
   input logic              rst_n,
   input logic              h_wr,
   input logic [ADDR_W-1:0] h_addr,
   input logic [DATA_W-1:0] h_wdata,
   input logic [CR_W-1:0]   cr_din,
   input logic              cr_cap_addr,
   input logic              cr_cap_data,
   input logic              cr_rd,
   input logic              cr_wr,
   input logic              cr_ack,
   input logic [CR_W-1:0]   dout_q
);
   logic [3:0] req;
   logic       any_req;
   assign req     = {cr_wr, cr_rd, cr_cap_data, cr_cap_addr};
   assign any_req = |req;

   assert_one_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req));

   assert_hold_until_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (any_req && !cr_ack) |=> $stable(req));

   assert_drop_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (any_req && cr_ack) |=> !any_req);

   assert_start_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(any_req) |-> $past(h_wr && h_wdata[0]));

   assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout_q) |-> $past(cr_ack && cr_rd));

   assert_stage_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cr_din) |-> $past(h_wr && (h_addr == ADDR_W'(OFS_DIN))));
endmodule

bind cr_bridge crb_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CR_W(CR_W), .OFS_DIN(OFS_DIN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr),
   .h_wdata(h_wdata), .cr_din(cr_din), .cr_cap_addr(cr_cap_addr),
   .cr_cap_data(cr_cap_data), .cr_rd(cr_rd), .cr_wr(cr_wr),
   .cr_ack(cr_ack), .dout_q(dout_q)
);

// File: tb/cr_bridge_test.sv
module cr_bridge_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_wr = 1'b0;
   logic [7:0]  h_addr = 8'h00;
   logic [31:0] h_wdata = 32'h0;
   logic [31:0] h_rdata;
   logic [15:0] cr_din;
   logic        cr_cap_addr, cr_cap_data, cr_rd, cr_wr;
   logic        cr_ack = 1'b0;
   logic [15:0] cr_dout = 16'h0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   cr_bridge uut (
      .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .cr_din(cr_din),
      .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data),
      .cr_rd(cr_rd), .cr_wr(cr_wr), .cr_ack(cr_ack), .cr_dout(cr_dout)
   );

   // ---------------- PHY-side register model ----------------
   logic [15:0] phy_mem [16];
   logic [15:0] phy_addr = 0, phy_data = 0, phy_last = 0;
   bit          phy_first = 0;
   bit          mute = 0;
   bit          spur = 0;
   int          delay = 0;
   int          cnt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         cr_ack <= 1'b0;
         cnt = 0;
         for (int i = 0; i < 16; i++) phy_mem[i] = 16'(i * 3);
      end else begin
         cr_ack <= 1'b0;
         if (spur) begin
            cr_ack  <= 1'b1;
            cr_dout <= 16'hDEAD;
            spur = 0;
         end else if (!cr_ack && !mute &&
                      (cr_cap_addr || cr_cap_data || cr_rd || cr_wr)) begin
            if (cnt >= delay) begin
               cnt = 0;
               cr_ack <= 1'b1;
               if (cr_cap_addr) begin phy_addr = cr_din; phy_first = 1; end
               if (cr_cap_data) phy_data = cr_din;
               if (cr_wr) phy_mem[phy_addr[3:0]] = phy_data;
               if (cr_rd) begin
                  cr_dout <= phy_first ? phy_last : phy_mem[phy_addr[3:0]];
                  phy_last = phy_mem[phy_addr[3:0]];
                  phy_first = 0;
               end
            end else cnt++;
         end
      end
   end

   // ---------------- behavioural reference model ----------------
   int          m_busy = -1;
   logic [15:0] m_stage = 0, m_dout = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = -1; m_stage = 0; m_dout = 0;
      end else begin
         if (m_busy >= 0 && cr_ack) begin
            if (m_busy == 2) m_dout = cr_dout;
            m_busy = -1;
         end else if (m_busy < 0 && h_wr && h_wdata[0]) begin
            case (h_addr)
               8'h14: m_busy = 0;
               8'h18: m_busy = 1;
               8'h1C: m_busy = 2;
               8'h20: m_busy = 3;
               default: ;
            endcase
         end
         if (h_wr && h_addr == 8'h0C) m_stage = h_wdata[15:0];
      end
   end

   function automatic logic [31:0] model_rdata(logic [7:0] a);
      case (a)
         8'h0C: return {16'h0, m_stage};
         8'h10: return {16'h0, m_dout};
         8'h14: return {31'h0, m_busy == 0};
         8'h18: return {31'h0, m_busy == 1};
         8'h1C: return {31'h0, m_busy == 2};
         8'h20: return {31'h0, m_busy == 3};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("R5 requests", {28'h0, cr_wr, cr_rd, cr_cap_data, cr_cap_addr},
               (m_busy >= 0) ? (32'h1 << m_busy) : 32'h0);
         check("R2 cr_din", {16'h0, cr_din}, {16'h0, m_stage});
         check("R8 readback", h_rdata, model_rdata(h_addr));
      end
   end

   // ---------------- host tasks ----------------
   task automatic hwrite(logic [7:0] a, logic [31:0] d);
      @(posedge clk); #2;
      h_wr = 1'b1; h_addr = a; h_wdata = d;
      @(posedge clk); #2;
      h_wr = 1'b0; h_wdata = 0;
   endtask

   task automatic hread(logic [7:0] a, output logic [31:0] d);
      @(posedge clk); #2;
      h_addr = a;
      @(negedge clk);
      d = h_rdata;
   endtask

   task automatic poll(logic [7:0] a);
      logic [31:0] v;
      v = 1;
      for (int i = 0; i < 40 && v[0]; i++) hread(a, v);
      check("R5 bit clears", v, 32'h0);
   endtask

   task automatic phy_write(logic [15:0] a, logic [15:0] d);
      hwrite(8'h0C, {16'h0, a}); hwrite(8'h14, 1); poll(8'h14);
      hwrite(8'h0C, {16'h0, d}); hwrite(8'h18, 1); poll(8'h18);
      hwrite(8'h20, 1); poll(8'h20);
   endtask

   task automatic phy_read(logic [15:0] a, output logic [31:0] r1,
                           output logic [31:0] r2);
      hwrite(8'h0C, {16'h0, a}); hwrite(8'h14, 1); poll(8'h14);
      hwrite(8'h1C, 1); poll(8'h1C); hread(8'h10, r1);
      hwrite(8'h1C, 1); poll(8'h1C); hread(8'h10, r2);
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      logic [31:0] v, r1, r2;
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1 reset state
      hread(8'h14, v); check("R1 cmd bit", v, 0);
      hread(8'h10, v); check("R1 result", v, 0);
      hread(8'h0C, v); check("R1 staging", v, 0);
      check("R1 requests", {28'h0, cr_wr, cr_rd, cr_cap_data, cr_cap_addr}, 0);
      // R2 staging keeps low 16 bits
      hwrite(8'h0C, 32'hABCD_5678);
      hread(8'h0C, v); check("R2 staging", v, 32'h5678);
      check("R2 cr_din", {16'h0, cr_din}, 32'h5678);
      // R3 writing 0 starts nothing
      hwrite(8'h1C, 32'hFFFF_FFFE);
      hread(8'h1C, v); check("R3 zero write", v, 0);
      // R3 request rises the cycle after the write
      hwrite(8'h0C, 0);
      mute = 1;
      @(posedge clk); #2; h_wr = 1; h_addr = 8'h14; h_wdata = 1;
      @(posedge clk); #2; h_wr = 0;
      check("R3 request rises", {31'h0, cr_cap_addr}, 1);
      // R6 second command ignored while busy
      hwrite(8'h1C, 1);
      hread(8'h1C, v); check("R6 ignored bit", v, 0);
      hread(8'h14, v); check("R6 busy kept", v, 1);
      // R4 no acknowledge: bit held
      repeat (30) @(posedge clk);
      hread(8'h14, v); check("R4 held without ack", v, 1);
      mute = 0;
      poll(8'h14);
      // R9 write then double read, fast PHY
      delay = 0;
      phy_write(16'h5, 16'hBEEF);
      phy_read(16'h5, r1, r2);
      check("R9 second read", r2, 32'hBEEF);
      // R9 slower PHY, stale first read
      delay = 3;
      phy_write(16'h7, 16'h1234);
      phy_read(16'h7, r1, r2);
      check("R9 stale first read", r1, 32'hBEEF);
      check("R9 second read slow", r2, 32'h1234);
      // R7 non-read ack leaves result alone
      phy_write(16'h2, 16'h0F0F);
      hread(8'h10, v); check("R7 held over write", v, 32'h1234);
      // R7 idle ack ignored
      @(posedge clk); #2; spur = 1;
      repeat (3) @(posedge clk);
      hread(8'h10, v); check("R7 idle ack", v, 32'h1234);
      // R8 unmapped offsets
      hread(8'h40, v); check("R8 unmapped", v, 0);
      hread(8'h04, v); check("R8 unmapped low", v, 0);
      repeat (3) @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule